// File: doc/BRIEF.md
# Dual-Bank Read Prefetch Buffer

This block stages read data inside a bus bridge. Data that comes back from the far-side bus is written on a fast system clock. The requesting master takes that data out on a slower, unrelated peripheral clock. Storage is split into two equal banks that take turns in a fixed order. While one bank fills, the other can be drained.

A bank is handed across the clock boundary only as a whole. The fill side passes "this bank is complete" to the drain side. The drain side passes "this bank is emptied" back. Each of these level flags crosses through a chain of synchronizer flops, and the two flags together form a four-phase handshake. Until that handshake has closed, a bank cannot be written again. The fill side therefore sees a wait signal whenever the next bank in turn still belongs to the drain side.

An attempt to write while the wait signal is high is discarded. A read when no word is presented is also discarded. Each of these sets a sticky error flag in its own clock domain, and only reset clears it.

Top module: `dbpf_buffer`

## Requirements
- R1: After reset, fill_wait, rd_valid, bank_ready, fill_err and drain_err are all 0.
- R2: Accepted writes go to bank 0 first. After DEPTH accepted writes, writing moves to bank 1, and after that the banks keep alternating. Inside a bank, words are kept in the order they were written.
- R3: Draining starts at bank 0 and alternates in the same order. While rd_valid is 1, rd_data shows the next word of the current bank. A read strobe taken while rd_valid is 1 moves to the following word on the next drain clock edge.
- R4: Once both banks are full and neither has been drained, fill_wait is 1.
- R5: fill_wait stays 1 while the next bank in turn still holds undrained data. It returns to 0 within a bounded number of fill cycles after that bank has been fully drained.
- R6: A bank becomes readable only after its last word has been written and its full flag has passed through the synchronizer. rd_valid rises within 20 drain cycles of the last write.
- R7: A write presented while fill_wait is 1 stores nothing and does not advance the fill position. On the next fill clock edge fill_err becomes 1, and it stays 1 until reset.
- R8: A read strobe presented while rd_valid is 0 does not advance the drain position. On the next drain clock edge drain_err becomes 1, and it stays 1 until reset.
- R9: bank_ready bit 0 reports that bank 0 is full and not yet drained. Bit 1 reports the same for bank 1. rd_valid is 1 only when the bank ready bit for the current drain bank is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fill_clk | input | 1 | Fill-side clock (fast system clock) |
| fill_rst_n | input | 1 | Fill-side asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one word |
| wr_data | input | DATA_W | Word to store |
| fill_wait | output | 1 | Fill side must hold off: the next bank is not free |
| fill_err | output | 1 | Sticky flag: a write was presented while fill_wait was 1 |
| drain_clk | input | 1 | Drain-side clock (slow peripheral clock) |
| drain_rst_n | input | 1 | Drain-side asynchronous reset, active low |
| rd_en | input | 1 | Read strobe: takes the presented word |
| rd_data | output | DATA_W | Word presented from the current drain bank |
| rd_valid | output | 1 | rd_data holds a valid word |
| bank_ready | output | 2 | Per-bank flag: bank is full and not yet drained |
| drain_err | output | 1 | Sticky flag: a read was presented while rd_valid was 0 |

## Verification
fill_wait follows fill-side state directly, so it is sampled on the falling fill edge right after the write that changes it. fill_err and drain_err settle one edge of their own clock after the offending strobe. rd_data moves to the next word one drain edge after an accepted read. The bench samples all of these at the following falling edge and compares them exactly. The results that cross the clock boundary take a variable number of cycles: a bank becoming readable, and fill_wait clearing after a drain. For these the bench polls each falling edge up to a fixed bound, and it fails the check if the bound passes. Right after the drain, before the handshake can have closed, it also checks that fill_wait is still 1.

// File: rtl/dbpf_pkg.sv
package dbpf_pkg;
   localparam int unsigned NBANK = 2;
   typedef logic [NBANK-1:0] bank_vec_t;

   function automatic bank_vec_t bank_onehot(input logic sel);
      return sel ? bank_vec_t'(2'b10) : bank_vec_t'(2'b01);
   endfunction
endpackage

// File: rtl/dbpf_sync.sv
module dbpf_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/dbpf_fill_ctrl.sv
module dbpf_fill_ctrl
   import dbpf_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  bank_vec_t     drained_s,
   output bank_vec_t     bank_we,
   output logic [AW-1:0] waddr,
   output bank_vec_t     fill_done,
   output logic          fill_wait,
   output logic          fill_err
);
   logic fsel;
   logic accept;
   logic last;

   assign fill_wait = fill_done[fsel] | drained_s[fsel];
   assign accept    = wr_en & ~fill_wait;
   assign last      = (waddr == AW'(DEPTH - 1));
   assign bank_we   = accept ? bank_onehot(fsel) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsel      <= 1'b0;
         waddr     <= '0;
         fill_done <= '0;
         fill_err  <= 1'b0;
      end else begin
         if (accept) begin
            if (last) begin
               waddr <= '0;
               fsel  <= ~fsel;
            end else begin
               waddr <= waddr + 1'b1;
            end
         end
         if (wr_en && fill_wait) fill_err <= 1'b1;
         for (int b = 0; b < NBANK; b++) begin
            if (accept && last && (int'(fsel) == b)) fill_done[b] <= 1'b1;
            else if (drained_s[b])                   fill_done[b] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dbpf_drain_ctrl.sv
module dbpf_drain_ctrl
   import dbpf_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  bank_vec_t     full_s,
   output logic          dsel,
   output logic [AW-1:0] raddr,
   output bank_vec_t     drain_done,
   output bank_vec_t     bank_ready,
   output logic          rd_valid,
   output logic          drain_err
);
   logic take;
   logic last;

   assign bank_ready = full_s & ~drain_done;
   assign rd_valid   = bank_ready[dsel];
   assign take       = rd_en & rd_valid;
   assign last       = (raddr == AW'(DEPTH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dsel       <= 1'b0;
         raddr      <= '0;
         drain_done <= '0;
         drain_err  <= 1'b0;
      end else begin
         if (take) begin
            if (last) begin
               raddr <= '0;
               dsel  <= ~dsel;
            end else begin
               raddr <= raddr + 1'b1;
            end
         end
         if (rd_en && !rd_valid) drain_err <= 1'b1;
         for (int b = 0; b < NBANK; b++) begin
            if (take && last && (int'(dsel) == b)) drain_done[b] <= 1'b1;
            else if (!full_s[b])                   drain_done[b] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dbpf_buffer.sv
module dbpf_buffer
   import dbpf_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              fill_clk,
   input  logic              fill_rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              fill_wait,
   output logic              fill_err,
   input  logic              drain_clk,
   input  logic              drain_rst_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [1:0]        bank_ready,
   output logic              drain_err
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2)       begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   if (DATA_W < 1)      begin : g_bad_width $error("DATA_W must be at least 1"); end

   bank_vec_t        bank_we;
   bank_vec_t        fill_done;
   bank_vec_t        drain_done;
   bank_vec_t        full_s;
   bank_vec_t        drained_s;
   bank_vec_t        ready;
   logic [AW-1:0]    waddr;
   logic [AW-1:0]    raddr;
   logic             dsel;
   logic [DATA_W-1:0] bank_q [NBANK];

   dbpf_fill_ctrl #(.DEPTH(DEPTH)) u_fill (
      .clk       (fill_clk),
      .rst_n     (fill_rst_n),
      .wr_en     (wr_en),
      .drained_s (drained_s),
      .bank_we   (bank_we),
      .waddr     (waddr),
      .fill_done (fill_done),
      .fill_wait (fill_wait),
      .fill_err  (fill_err)
   );

   dbpf_drain_ctrl #(.DEPTH(DEPTH)) u_drain (
      .clk        (drain_clk),
      .rst_n      (drain_rst_n),
      .rd_en      (rd_en),
      .full_s     (full_s),
      .dsel       (dsel),
      .raddr      (raddr),
      .drain_done (drain_done),
      .bank_ready (ready),
      .rd_valid   (rd_valid),
      .drain_err  (drain_err)
   );

   dbpf_sync #(.STAGES(SYNC_STAGES), .WIDTH(NBANK)) u_sync_full (
      .clk   (drain_clk),
      .rst_n (drain_rst_n),
      .d     (fill_done),
      .q     (full_s)
   );

   dbpf_sync #(.STAGES(SYNC_STAGES), .WIDTH(NBANK)) u_sync_drained (
      .clk   (fill_clk),
      .rst_n (fill_rst_n),
      .d     (drain_done),
      .q     (drained_s)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge fill_clk) begin
         if (bank_we[b]) mem[waddr] <= wr_data;
      end
      assign bank_q[b] = mem[raddr];
   end

   assign rd_data    = bank_q[dsel];
   assign bank_ready = ready;
endmodule

// File: rtl/dbpf_buffer_chk.sv
module dbpf_buffer_chk (
   input logic       fill_clk,
   input logic       fill_rst_n,
   input logic       drain_clk,
   input logic       drain_rst_n,
   input logic       wr_en,
   input logic       fill_wait,
   input logic       fill_err,
   input logic       rd_en,
   input logic       rd_valid,
   input logic [1:0] bank_ready,
   input logic       drain_err,
   input logic [1:0] fill_done
);
   // R4: both banks complete on the fill side forces the fill side to hold off
   p_wait_both_full_r4: assert property (@(posedge fill_clk) disable iff (!fill_rst_n)
      (fill_done == 2'b11) |-> fill_wait);

   // R7: a write during wait is flagged, and the flag holds
   p_bad_write_flag_r7: assert property (@(posedge fill_clk) disable iff (!fill_rst_n)
      (wr_en && fill_wait) |=> fill_err);
   p_fill_err_sticky_r7: assert property (@(posedge fill_clk) disable iff (!fill_rst_n)
      fill_err |=> fill_err);

   // R8: a read with nothing presented is flagged, and the flag holds
   p_bad_read_flag_r8: assert property (@(posedge drain_clk) disable iff (!drain_rst_n)
      (rd_en && !rd_valid) |=> drain_err);
   p_drain_err_sticky_r8: assert property (@(posedge drain_clk) disable iff (!drain_rst_n)
      drain_err |=> drain_err);

   // R9: a presented word always belongs to a ready bank
   p_valid_has_ready_r9: assert property (@(posedge drain_clk) disable iff (!drain_rst_n)
      rd_valid |-> (bank_ready != 2'b00));
endmodule

bind dbpf_buffer dbpf_buffer_chk u_chk (
   .fill_clk    (fill_clk),
   .fill_rst_n  (fill_rst_n),
   .drain_clk   (drain_clk),
   .drain_rst_n (drain_rst_n),
   .wr_en       (wr_en),
   .fill_wait   (fill_wait),
   .fill_err    (fill_err),
   .rd_en       (rd_en),
   .rd_valid    (rd_valid),
   .bank_ready  (bank_ready),
   .drain_err   (drain_err),
   .fill_done   (fill_done)
);

// File: tb/dbpf_buffer_tb.sv
`timescale 1ns/100ps
module dbpf_buffer_tb;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned DEPTH  = 8;
   localparam int          NROW   = 4;
   localparam logic [31:0] ROW_BASE [NROW] = '{32'h1000_0000, 32'hA5A5_0000, 32'hFFFF_FFF0, 32'h0000_0001};
   localparam logic [31:0] ROW_STEP [NROW] = '{32'h0000_0001, 32'h0000_0100, 32'h0000_0003, 32'h8000_0000};

   logic              fclk = 1'b0;
   logic              dclk = 1'b0;
   logic              frst_n = 1'b0;
   logic              drst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_en = 1'b0;
   logic              fill_wait, fill_err, rd_valid, drain_err;
   logic [DATA_W-1:0] rd_data;
   logic [1:0]        bank_ready;

   int checks = 0;
   int failures = 0;

   always #5 fclk = ~fclk;
   always #15.2 dclk = ~dclk;

   dbpf_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(2)) u_dut (
      .fill_clk(fclk), .fill_rst_n(frst_n), .wr_en(wr_en), .wr_data(wr_data),
      .fill_wait(fill_wait), .fill_err(fill_err),
      .drain_clk(dclk), .drain_rst_n(drst_n), .rd_en(rd_en), .rd_data(rd_data),
      .rd_valid(rd_valid), .bank_ready(bank_ready), .drain_err(drain_err)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Streams one group of DEPTH words, holding off while fill_wait is high.
   task automatic fill_group(input logic [31:0] base, input logic [31:0] step);
      int n = 0;
      int guard = 0;
      while (n < DEPTH && guard < 400) begin
         @(negedge fclk);
         guard++;
         if (!fill_wait) begin
            wr_en = 1'b1;
            wr_data = base + step * n;
            n++;
         end else begin
            wr_en = 1'b0;
         end
      end
      @(negedge fclk);
      wr_en = 1'b0;
      check(n == DEPTH, "R5 fill group accepted", n, DEPTH);
   endtask

   // Takes DEPTH words and compares each with the expected sequence.
   task automatic drain_group(input logic [31:0] base, input logic [31:0] step, input string req);
      for (int i = 0; i < DEPTH; i++) begin
         int guard = 0;
         @(negedge dclk);
         while (!rd_valid && guard < 20) begin
            @(negedge dclk);
            guard++;
         end
         check(rd_valid === 1'b1, "R6 rd_valid within bound", rd_valid, 1);
         check(rd_data === base + step * i, req, rd_data, base + step * i);
         rd_en = 1'b1;
         @(negedge dclk);
         rd_en = 1'b0;
      end
   endtask

   task automatic wait_ready(input logic [1:0] exp, input string req);
      int guard = 0;
      @(negedge dclk);
      while (bank_ready !== exp && guard < 20) begin
         @(negedge dclk);
         guard++;
      end
      check(bank_ready === exp, req, bank_ready, exp);
   endtask

   initial begin
      repeat (150000) @(posedge fclk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge dclk);
      frst_n = 1'b1;
      drst_n = 1'b1;
      @(negedge fclk);
      // R1: reset state
      check(fill_wait === 1'b0, "R1 fill_wait", fill_wait, 0);
      check(fill_err === 1'b0, "R1 fill_err", fill_err, 0);
      @(negedge dclk);
      check(rd_valid === 1'b0, "R1 rd_valid", rd_valid, 0);
      check(bank_ready === 2'b00, "R1 bank_ready", bank_ready, 0);
      check(drain_err === 1'b0, "R1 drain_err", drain_err, 0);

      // Vector table: each row fills one group, then drains it; banks alternate 0,1,0,1 (R2, R3, R6, R9)
      for (int r = 0; r < NROW; r++) begin
         fill_group(ROW_BASE[r], ROW_STEP[r]);
         wait_ready(2'b01 << (r % 2), "R9 bank_ready bit of filled bank");
         drain_group(ROW_BASE[r], ROW_STEP[r], "R3 drained word in write order");
      end

      // R4: two groups without draining fill both banks and force wait
      fill_group(32'h0A00_0000, 32'h11);
      fill_group(32'h0B00_0000, 32'h22);
      @(negedge fclk);
      check(fill_wait === 1'b1, "R4 wait with both banks full", fill_wait, 1);

      // R7: write during wait is ignored and flagged
      wr_en = 1'b1;
      wr_data = 32'hDEAD_BEEF;
      @(negedge fclk);
      wr_en = 1'b0;
      check(fill_err === 1'b1, "R7 fill_err after write during wait", fill_err, 1);
      wait_ready(2'b11, "R9 both banks ready");

      // R2/R7: bank 0 drains first and the rejected word never landed
      drain_group(32'h0A00_0000, 32'h11, "R2 bank 0 drains first, R7 no stray word");
      @(negedge fclk);
      check(fill_wait === 1'b1, "R5 wait held until handshake closes", fill_wait, 1);
      begin
         int guard = 0;
         while (fill_wait && guard < 80) begin
            @(negedge fclk);
            guard++;
         end
         check(fill_wait === 1'b0, "R5 wait released after drain", fill_wait, 0);
      end
      fill_group(32'h0C00_0000, 32'h33);
      drain_group(32'h0B00_0000, 32'h22, "R2 bank 1 drains second");
      drain_group(32'h0C00_0000, 32'h33, "R3 refilled bank 0 drains third");

      // R8: read with nothing presented is ignored and flagged
      @(negedge dclk);
      check(rd_valid === 1'b0, "R8 nothing presented", rd_valid, 0);
      rd_en = 1'b1;
      @(negedge dclk);
      rd_en = 1'b0;
      check(drain_err === 1'b1, "R8 drain_err after empty read", drain_err, 1);
      check(rd_valid === 1'b0, "R8 still nothing presented", rd_valid, 0);
      fill_group(32'h0D00_0000, 32'h44);
      drain_group(32'h0D00_0000, 32'h44, "R8 empty read did not advance position");

      check(fill_err === 1'b1, "R7 fill_err sticky", fill_err, 1);
      check(drain_err === 1'b1, "R8 drain_err sticky", drain_err, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule